// File: doc/BRIEF.md
# User-Mode Memory Access Permission Checker

This block keeps a small table of protection regions and judges every data access a core makes against that table. Each region has a permission/mode byte and a word-granular address register. Machine software programs both through a single-cycle write port. For each load or store the block receives the byte address, the size, the direction and the privilege level. In the same cycle it returns either a permit or a fault together with a trap cause code.

The permit/fault decision also drives two enables. The first is the memory write enable for stores. The second is the destination-register write enable for loads. A denied access therefore leaves no trace in memory or in the register file. A second lookup port checks an instruction-fetch address for execute permission. That result decides whether a user-mode wait-for-interrupt may stall the core or must trap at once.

When more than one region covers an address, the lowest-numbered covering region alone sets the rights. A narrow region with a low index can therefore carve an exception out of a broad region with a higher index.

Top module: `pmp_checker`

## Requirements
- R1: After a synchronous reset, every region is in mode OFF, so every user-mode load or store is denied until software programs a region.
- R2: A write with `cfg_sel`=0 loads bits [4:0] of `cfg_wdata` into the selected region's mode byte. The layout is bit0 read, bit1 write, bit2 execute and bits [4:3] address mode, where 00 is OFF, 01 is reserved, 10 is a single word and 11 is a power-of-two block. A write with `cfg_sel`=1 loads bits [29:0] as the region's word address, which is the byte address shifted right by 2. The new value governs checks from the next cycle on.
- R3: In single-word mode a region covers exactly the 4 bytes whose address bits [31:2] equal its word address. Byte accesses at offsets 0 to 3 and halfword accesses at offsets 0 and 2 inside that word are judged by that region. A user access that is not naturally aligned for its size (`req_size`: 0 byte, 1 halfword, 2 word, 3 reserved) is denied.
- R4: In power-of-two mode, n trailing ones in the word address give a block of 2^(n+3) bytes, and only the address bits above that size are compared. A word address of all ones covers the whole address space.
- R5: When several regions cover an address, only the lowest-numbered covering region decides the permissions.
- R6: A user-mode load that is denied raises `fault_valid` in the same cycle with cause 5.
- R7: A user-mode store that is denied raises `fault_valid` in the same cycle with cause 7.
- R8: Regions in mode OFF or the reserved mode never cover any address, and a user access covered by no region is denied.
- R9: Machine-mode loads and stores are never denied, and machine-mode fetches always have execute permission.
- R10: `fault_valid` is high only while `req_valid` is high, and `fault_cause` is 0 whenever `fault_valid` is low.
- R11: `mem_we` is high only for a permitted store and `rd_we` only for a permitted load, so a denied access causes no memory or register write.
- R12: `x_allow` is high for a user fetch address only when its lowest-numbered covering region has execute permission.
- R13: For a wait-for-interrupt request, a user-mode one traps (`wfi_trap`) if its fetch address lacks execute permission or the timeout-wait input is set, and it stalls (`wfi_stall`) only when it does not trap. A trapped request never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Region register write strobe |
| cfg_idx | input | $clog2(NUM_REGIONS) | Region written |
| cfg_sel | input | 1 | 0: mode byte, 1: word address |
| cfg_wdata | input | ADDR_W | Write data |
| priv_user | input | 1 | 1: user mode, 0: machine mode |
| req_valid | input | 1 | Data access present |
| req_store | input | 1 | 1: store, 0: load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Data byte address |
| fetch_addr | input | ADDR_W | Instruction fetch byte address |
| wfi_req | input | 1 | Wait-for-interrupt being issued |
| wfi_tw | input | 1 | Timeout-wait control bit |
| fault_valid | output | 1 | Data access denied |
| fault_cause | output | 4 | 5 load fault, 7 store fault, else 0 |
| mem_we | output | 1 | Permitted store may write memory |
| rd_we | output | 1 | Permitted load may write its register |
| x_allow | output | 1 | Fetch address executable |
| wfi_stall | output | 1 | Core may sleep on the wait |
| wfi_trap | output | 1 | Wait must trap without stalling |

## Verification
The directed patterns first put a one-word region 0 inside an all-space region 1 and toggle the read and write rights of region 0. This separates priority from plain matching: the neighbouring word stays open while the covered word is judged by region 0 alone. Byte and halfword accesses at the top of that word, and misaligned ones, show whether sub-word accesses fall into the right region. A 64-byte block and the addresses just outside it separate a correct trailing-ones mask from one that is off by one in either direction. Machine-mode traffic, reserved-mode regions, fetch addresses with and without execute permission, and waits with the timeout bit set and clear cover the remaining decisions. A long random phase then mixes register writes and accesses near the programmed regions.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  typedef enum logic [1:0] {
    MATCH_OFF   = 2'b00,
    MATCH_RSVD  = 2'b01,
    MATCH_WORD  = 2'b10,
    MATCH_BLOCK = 2'b11
  } match_mode_e;

  typedef struct packed {
    logic [2:0]  pad;
    match_mode_e mode;
    logic        x;
    logic        w;
    logic        r;
  } region_cfg_t;

  localparam logic [3:0] CAUSE_NONE  = 4'd0;
  localparam logic [3:0] CAUSE_LOAD  = 4'd5;
  localparam logic [3:0] CAUSE_STORE = 4'd7;

endpackage

// File: rtl/pmp_region_regs.sv
module pmp_region_regs
  import pmp_chk_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 32,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int WA_W       = ADDR_W - 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [IDX_W-1:0]                 idx,
  input  logic                             sel,
  input  logic [ADDR_W-1:0]                wdata,
  output region_cfg_t [NUM_REGIONS-1:0]    cfg_o,
  output logic [NUM_REGIONS-1:0][WA_W-1:0] addr_o
);

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_entry
    region_cfg_t      cfg_q;
    logic [WA_W-1:0]  addr_q;
    logic             hit_idx;

    assign hit_idx = we && (idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q  <= '0;
        addr_q <= '0;
      end else if (hit_idx) begin
        if (!sel) begin
          cfg_q.pad  <= 3'b000;
          cfg_q.mode <= match_mode_e'(wdata[4:3]);
          cfg_q.x    <= wdata[2];
          cfg_q.w    <= wdata[1];
          cfg_q.r    <= wdata[0];
        end else begin
          addr_q <= wdata[WA_W-1:0];
        end
      end
    end

    assign cfg_o[g]  = cfg_q;
    assign addr_o[g] = addr_q;
  end

endmodule

// File: rtl/pmp_region_match.sv
module pmp_region_match
  import pmp_chk_pkg::*;
#(
  parameter int WA_W = 30
) (
  input  region_cfg_t     cfg,
  input  logic [WA_W-1:0] region_addr,
  input  logic [WA_W-1:0] word_addr,
  output logic            hit
);

  logic [WA_W-1:0] care_mask;

  // Trailing ones plus the first zero above them are don't-care bits.
  assign care_mask = ~(region_addr ^ (region_addr + WA_W'(1)));

  always_comb begin
    unique case (cfg.mode)
      MATCH_WORD:  hit = (word_addr == region_addr);
      MATCH_BLOCK: hit = (((word_addr ^ region_addr) & care_mask) == '0);
      default:     hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmp_lookup.sv
module pmp_lookup
  import pmp_chk_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int WA_W        = 30
) (
  input  region_cfg_t [NUM_REGIONS-1:0]    cfg,
  input  logic [NUM_REGIONS-1:0][WA_W-1:0] region_addr,
  input  logic [WA_W-1:0]                  word_addr,
  output logic                             any_hit,
  output region_cfg_t                      win_cfg
);

  logic [NUM_REGIONS-1:0] hits;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    pmp_region_match #(.WA_W(WA_W)) i_match (
      .cfg         (cfg[g]),
      .region_addr (region_addr[g]),
      .word_addr   (word_addr),
      .hit         (hits[g])
    );
  end

  assign any_hit = |hits;

  // Scan from the top so the lowest covering index is assigned last.
  always_comb begin
    win_cfg = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hits[i]) win_cfg = cfg[i];
    end
  end

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_chk_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 32,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int WA_W       = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              priv_user,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              wfi_req,
  input  logic              wfi_tw,
  output logic              fault_valid,
  output logic [3:0]        fault_cause,
  output logic              mem_we,
  output logic              rd_we,
  output logic              x_allow,
  output logic              wfi_stall,
  output logic              wfi_trap
);

  region_cfg_t [NUM_REGIONS-1:0]    cfg_all;
  logic [NUM_REGIONS-1:0][WA_W-1:0] addr_all;

  pmp_region_regs #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) i_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .idx    (cfg_idx),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .cfg_o  (cfg_all),
    .addr_o (addr_all)
  );

  logic        d_hit, f_hit;
  region_cfg_t d_cfg, f_cfg;

  pmp_lookup #(.NUM_REGIONS(NUM_REGIONS), .WA_W(WA_W)) i_data_lu (
    .cfg         (cfg_all),
    .region_addr (addr_all),
    .word_addr   (req_addr[ADDR_W-1:2]),
    .any_hit     (d_hit),
    .win_cfg     (d_cfg)
  );

  pmp_lookup #(.NUM_REGIONS(NUM_REGIONS), .WA_W(WA_W)) i_fetch_lu (
    .cfg         (cfg_all),
    .region_addr (addr_all),
    .word_addr   (fetch_addr[ADDR_W-1:2]),
    .any_hit     (f_hit),
    .win_cfg     (f_cfg)
  );

  logic aligned;
  logic right_ok;
  logic user_ok;

  always_comb begin
    unique case (req_size)
      2'd0:    aligned = 1'b1;
      2'd1:    aligned = ~req_addr[0];
      2'd2:    aligned = (req_addr[1:0] == 2'b00);
      default: aligned = 1'b0;
    endcase
  end

  assign right_ok    = req_store ? d_cfg.w : d_cfg.r;
  assign user_ok     = d_hit && aligned && right_ok;

  assign fault_valid = req_valid && priv_user && !user_ok;
  assign fault_cause = !fault_valid ? CAUSE_NONE :
                       (req_store ? CAUSE_STORE : CAUSE_LOAD);
  assign mem_we      = req_valid &&  req_store && !fault_valid;
  assign rd_we       = req_valid && !req_store && !fault_valid;

  assign x_allow     = !priv_user || (f_hit && f_cfg.x);
  assign wfi_trap    = wfi_req && priv_user && (!x_allow || wfi_tw);
  assign wfi_stall   = wfi_req && !wfi_trap;

endmodule

// File: rtl/pmp_checker_sva.sv
module pmp_checker_sva
  import pmp_chk_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 32,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [IDX_W-1:0]  cfg_idx,
  input logic              cfg_sel,
  input logic [ADDR_W-1:0] cfg_wdata,
  input logic              priv_user,
  input logic              req_valid,
  input logic              req_store,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              wfi_req,
  input logic              wfi_tw,
  input logic              fault_valid,
  input logic [3:0]        fault_cause,
  input logic              mem_we,
  input logic              rd_we,
  input logic              x_allow,
  input logic              wfi_stall,
  input logic              wfi_trap
);

  // R1
  reset_deny_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && req_valid && priv_user) |-> fault_valid);

  // R6
  load_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_valid && !req_store) |-> (fault_cause == CAUSE_LOAD));

  // R7
  store_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_valid && req_store) |-> (fault_cause == CAUSE_STORE));

  // R9
  mach_nofault_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !priv_user) |-> (!fault_valid && x_allow));

  // R10
  fault_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> req_valid);

  // R10
  cause_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !fault_valid |-> (fault_cause == CAUSE_NONE));

  // R11
  no_side_effect_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (!mem_we && !rd_we));

  // R13
  wfi_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wfi_stall, wfi_trap}));

  // R13
  wfi_tw_chk: assert property (@(posedge clk) disable iff (rst)
    (wfi_req && priv_user && wfi_tw) |-> wfi_trap);

endmodule

bind pmp_checker pmp_checker_sva #(
  .NUM_REGIONS (NUM_REGIONS),
  .ADDR_W      (ADDR_W)
) i_sva (.*);

// File: tb/test_pmp_checker.sv
module test_pmp_checker;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        priv_user = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_addr = '0;
  logic [31:0] fetch_addr = '0;
  logic        wfi_req = 1'b0;
  logic        wfi_tw = 1'b0;
  logic        fault_valid;
  logic [3:0]  fault_cause;
  logic        mem_we, rd_we, x_allow, wfi_stall, wfi_trap;

  pmp_checker #(.NUM_REGIONS(N), .ADDR_W(32)) i_pmp_checker (.*);

  always #4 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;

  // Behavioural reference state
  logic [7:0]  m_cfg [N];
  logic [29:0] m_adr [N];

  function automatic bit covers(int i, logic [31:0] a);
    int n;
    logic [31:0] base;
    if (m_cfg[i][4:3] == 2'b10) return a[31:2] == m_adr[i];
    if (m_cfg[i][4:3] != 2'b11) return 0;
    n = 0;
    while (n < 30 && m_adr[i][n]) n++;
    if (n >= 29) return 1;
    base = {m_adr[i], 2'b00};
    return (a >> (n + 3)) == (base >> (n + 3));
  endfunction

  function automatic int winner(logic [31:0] a);
    for (int i = 0; i < N; i++) if (covers(i, a)) return i;
    return -1;
  endfunction

  task automatic step(string tag);
    int w, fw;
    bit ok_al, e_fv, e_x, e_trap;
    logic [3:0] e_cause;
    #1;
    w  = winner(req_addr);
    fw = winner(fetch_addr);
    case (req_size)
      2'd0: ok_al = 1;
      2'd1: ok_al = (req_addr[0] == 0);
      2'd2: ok_al = (req_addr[1:0] == 0);
      default: ok_al = 0;
    endcase
    e_fv = 0;
    if (req_valid && priv_user) begin
      if (w < 0 || !ok_al) e_fv = 1;
      else if (req_store && !m_cfg[w][1]) e_fv = 1;
      else if (!req_store && !m_cfg[w][0]) e_fv = 1;
    end
    e_cause = !e_fv ? 4'd0 : (req_store ? 4'd7 : 4'd5);
    e_x = !priv_user || (fw >= 0 && m_cfg[fw][2]);
    e_trap = wfi_req && priv_user && (!e_x || wfi_tw);
    vectors++;
    if (fault_valid !== e_fv || fault_cause !== e_cause ||
        mem_we !== (req_valid && req_store && !e_fv) ||
        rd_we !== (req_valid && !req_store && !e_fv) ||
        x_allow !== e_x || wfi_trap !== e_trap ||
        wfi_stall !== (wfi_req && !e_trap)) begin
      miscompares++;
      $display("FAIL %s addr=%h: act fv=%b cause=%0d mwe=%b rwe=%b x=%b st=%b tr=%b exp fv=%b cause=%0d x=%b tr=%b",
               tag, req_addr, fault_valid, fault_cause, mem_we, rd_we, x_allow,
               wfi_stall, wfi_trap, e_fv, e_cause, e_x, e_trap);
    end
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_cfg[i] = '0; m_adr[i] = '0; end
    end else if (cfg_we) begin
      if (!cfg_sel) m_cfg[cfg_idx] = {3'b000, cfg_wdata[4:0]};
      else          m_adr[cfg_idx] = cfg_wdata[29:0];
    end
    @(negedge clk);
  endtask

  task automatic wr(int idx, bit sel, logic [31:0] d, string tag);
    cfg_we = 1; cfg_idx = 2'(idx); cfg_sel = sel; cfg_wdata = d; req_valid = 0;
    step(tag);
    cfg_we = 0;
  endtask

  task automatic acc(bit user, bit st, logic [1:0] sz, logic [31:0] a, string tag);
    priv_user = user; req_valid = 1; req_store = st; req_size = sz; req_addr = a;
    wfi_req = 0;
    step(tag);
    req_valid = 0;
  endtask

  task automatic wfi(bit user, logic [31:0] fa, bit tw, string tag);
    priv_user = user; fetch_addr = fa; wfi_req = 1; wfi_tw = tw; req_valid = 0;
    step(tag);
    wfi_req = 0; wfi_tw = 0;
  endtask

  localparam logic [31:0] S = 32'h2000_0040;

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_cfg[i] = '0; m_adr[i] = '0; end
    @(negedge clk);
    req_valid = 1; priv_user = 1; req_addr = S;
    step("R1 in reset");
    step("R1 in reset");
    rst = 0;
    acc(1, 0, 2, S, "R1 load after reset");
    acc(1, 1, 2, 32'h0, "R1 store after reset");

    // Broad region 1, narrow region 0 (still OFF)
    wr(1, 0, 32'h1F, "R2 cfg1");
    wr(1, 1, 32'hFFFF_FFFF, "R2 addr1");
    wr(0, 1, S >> 2, "R2 addr0");
    acc(1, 1, 2, S, "R4 whole space store");
    acc(1, 0, 2, S, "R4 whole space load");

    // Region 0 write+exec only
    wr(0, 0, 32'h16, "R2 cfg0 WX");
    acc(1, 1, 2, S, "R5 store allowed");
    acc(1, 0, 2, S, "R6 R5 load denied");
    acc(1, 0, 2, S + 4, "R3 neighbour word");
    acc(1, 0, 2, S - 4, "R3 neighbour below");
    acc(1, 0, 1, S + 2, "R3 R6 half load top");
    acc(1, 0, 0, S + 3, "R3 R6 byte load top");
    acc(1, 1, 1, S + 2, "R3 half store");
    acc(1, 1, 0, S + 3, "R3 byte store");

    // Region 0 read+exec only
    wr(0, 0, 32'h15, "R2 cfg0 RX");
    acc(1, 1, 2, S, "R7 R11 word store denied");
    acc(1, 1, 1, S + 2, "R7 half store denied");
    acc(1, 1, 0, S + 3, "R7 byte store denied");
    acc(1, 0, 2, S, "R11 load allowed");
    acc(1, 0, 1, S + 2, "R3 half load");
    acc(1, 0, 0, S + 3, "R3 byte load");
    acc(1, 0, 1, S + 1, "R3 misaligned half");
    acc(1, 0, 2, S + 2, "R3 misaligned word");
    acc(1, 0, 3, S, "R3 reserved size");
    acc(0, 1, 2, S, "R9 machine store");

    // Reserved mode and no match
    wr(0, 0, 32'h0F, "R8 rsvd mode");
    wr(1, 0, 32'h00, "R8 off");
    acc(1, 0, 2, S, "R8 no match load");
    acc(1, 1, 2, S, "R8 no match store");
    acc(0, 0, 2, S, "R9 machine no match");

    // 64-byte block at 0x1000_0000, read only
    wr(2, 1, 32'h0400_0007, "R2 addr2");
    wr(2, 0, 32'h19, "R2 cfg2");
    acc(1, 0, 2, 32'h1000_0000, "R4 block low");
    acc(1, 0, 2, 32'h1000_003C, "R4 block high");
    acc(1, 0, 2, 32'h1000_0040, "R4 above block");
    acc(1, 0, 2, 32'h0FFF_FFFC, "R4 below block");
    acc(1, 1, 2, 32'h1000_0010, "R4 R7 block store");

    // Exec region and waits
    wr(3, 1, 32'h0C00_0000, "R2 addr3");
    wr(3, 0, 32'h14, "R2 cfg3");
    wfi(1, 32'h3000_0000, 0, "R12 R13 exec stall");
    wfi(1, 32'h3000_0000, 1, "R13 tw trap");
    wfi(1, 32'h3000_0004, 0, "R12 R13 no exec trap");
    wfi(0, 32'h3000_0004, 1, "R9 R13 machine wfi");

    // Random mix
    for (int k = 0; k < 600; k++) begin
      int r;
      r = $urandom_range(0, 7);
      if (r == 0)
        wr($urandom_range(0, N - 1), 0, $urandom, "RND R2");
      else if (r == 1)
        wr($urandom_range(0, N - 1), 1,
           {4'h0, 4'h4, 16'h0, 8'($urandom)}, "RND R2 R4");
      else begin
        priv_user = ($urandom_range(0, 3) != 0);
        req_valid = ($urandom_range(0, 7) != 0);
        req_store = 1'($urandom);
        req_size  = 2'($urandom);
        req_addr  = {8'h10, 16'h0, 8'($urandom)};
        fetch_addr = {8'h10, 16'h0, 8'($urandom)};
        wfi_req   = 1'($urandom);
        wfi_tw    = 1'($urandom);
        step("RND R3 R4 R5 R10 R11 R12 R13");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule